// File: doc/BRIEF.md
# Ten-bit Compare and PWM Timer

This block is a general purpose 10-bit up-counting timer for a microcontroller-class chip. Software programs two 8-bit control bytes and two compare values through a small byte-wide register port. The first control byte enables the timer, pauses it and chooses what advances the count: a system-clock based enable, a divided high-speed enable, a slow sub-clock enable, or a rising or falling edge on an external input pin. The pin is brought into the system clock domain through a synchronizer before its edges are detected.

The second control byte picks one of three behaviours. In compare mode the output pin is set, cleared or toggled whenever the count leaves the value of compare register A. In PWM mode one compare register fixes the period and the other the duty, and the pin is active from count zero until the duty value is reached. In timer mode the pin is left alone and only the count and the match pulse are of interest. A small sequencer with the states IDLE, LOAD, COUNT and PAUSE tracks the enable and pause bits; entering LOAD on a rising enable clears the count and reloads the programmed starting level of the pin.

Top module: `ctr_out_timer`

## Requirements
- R1: After reset every register reads 0x00, the output pin is 0 and the match pulse is 0.
- R2: Address 0 holds the first control byte: bit 7 pause, bits 6:4 source select, bit 3 enable; bits 2:0 always read 0. Address 1 holds the second control byte and reads back all eight bits. Address 2 is A[7:0], address 3 bits 1:0 are A[9:8], address 4 bits 2:0 are P, addresses 5 and 6 return count[7:0] and count[9:8].
- R3: The count advances by one for each pulse of the selected source: 000 the divide-by-4 system enable, 001 every system clock, 010 the divide-by-16 high-speed enable, 011 the divide-by-64 high-speed enable, 100 and 101 the sub-clock enable; other sources have no effect.
- R4: Source 110 counts rising edges and source 111 counts falling edges of the external pin after synchronization.
- R5: While pause (control byte 0 bit 7) is 1 the count holds; after pause returns to 0 counting continues from the held value on the very next clock.
- R6: A 0-to-1 change of enable clears the count to zero two clocks after the write; a 1-to-0 change stops the count at its current value.
- R7: The count wraps to zero after reaching its top value. The top is A when it is selected, otherwise P*128-1 (P=0 gives 1023). Outside PWM mode control byte 1 bit 0 set selects A; in PWM mode control byte 1 bit 1 set selects A.
- R8: The match output pulses for one clock, one clock after a counting step in which the count equals A.
- R9: In compare mode (control byte 1 bits 7:6 = 00) a match applies output function bits 5:4: 00 no change, 01 drive low, 10 drive high, 11 toggle.
- R10: In compare and PWM modes a rising enable loads the pin level from bit 3; bit 2 set inverts the pin in every mode.
- R11: In PWM mode (bits 7:6 = 10) with function bits 1x, each step sets the level to (next count < duty), where duty is A when bit 1 is 0 and P*128 when bit 1 is 1; function 00 drives inactive and 01 drives active.
- R12: In timer mode (bits 7:6 = 11) the pin keeps its level, neither rising enable nor matches changing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| tick_sys4_i | input | 1 | System clock divided by 4 enable |
| tick_hs16_i | input | 1 | High-speed clock divided by 16 enable |
| tick_hs64_i | input | 1 | High-speed clock divided by 64 enable |
| tick_sub_i | input | 1 | Sub-clock enable |
| ext_clk_i | input | 1 | Asynchronous external count input |
| tmr_pin_o | output | 1 | Timer output pin |
| tmr_irq_o | output | 1 | Compare-A match pulse |

## Verification
A corrupted count shows up at the count readback within one clock and, in PWM mode, as a pin edge in the wrong cycle of the same period. A sequencer stuck outside LOAD shows as a nonzero count or a wrong start level two clocks after the enable write, while a sequencer that misses the pause or disable leaves the count moving during the hold window checked immediately afterwards. A wrong output level register is visible on the pin at the first match or first PWM step, and the bench compares pin, match pulse and count every clock against its own model of the period, duty and output function.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MD_CMP = 2'b00,
        MD_RSV = 2'b01,
        MD_PWM = 2'b10,
        MD_TMR = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2,
        ST_PAUSE = 2'd3
    } tmr_state_e;

    typedef struct packed {
        logic       pause;
        logic [2:0] csel;
        logic       en;
        logic [2:0] rsv;
    } ctl0_t;

    typedef struct packed {
        tmr_mode_e  mode;
        logic [1:0] ofun;
        logic       init;
        logic       pol;
        logic       dpsel;
        logic       clrsel;
    } ctl1_t;

    localparam logic [2:0] ADR_CTL0  = 3'd0;
    localparam logic [2:0] ADR_CTL1  = 3'd1;
    localparam logic [2:0] ADR_A_LO  = 3'd2;
    localparam logic [2:0] ADR_A_HI  = 3'd3;
    localparam logic [2:0] ADR_P     = 3'd4;
    localparam logic [2:0] ADR_CNT_L = 3'd5;
    localparam logic [2:0] ADR_CNT_H = 3'd6;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int P_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       rdata,
    output ctl0_t            ctl0,
    output ctl1_t            ctl1,
    output logic [CNT_W-1:0] cmp_a,
    output logic [P_W-1:0]   cmp_p
);
    localparam int HI_W = CNT_W - 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl0  <= '0;
            ctl1  <= '0;
            cmp_a <= '0;
            cmp_p <= '0;
        end else if (we) begin
            case (addr)
                ADR_CTL0: ctl0 <= ctl0_t'({wdata[7:3], 3'b000});
                ADR_CTL1: ctl1 <= ctl1_t'(wdata);
                ADR_A_LO: cmp_a[7:0] <= wdata;
                ADR_A_HI: cmp_a[CNT_W-1:8] <= wdata[HI_W-1:0];
                ADR_P:    cmp_p <= wdata[P_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADR_CTL0:  rdata = ctl0;
            ADR_CTL1:  rdata = ctl1;
            ADR_A_LO:  rdata = cmp_a[7:0];
            ADR_A_HI:  rdata = {{(8-HI_W){1'b0}}, cmp_a[CNT_W-1:8]};
            ADR_P:     rdata = {{(8-P_W){1'b0}}, cmp_p};
            ADR_CNT_L: rdata = cnt[7:0];
            ADR_CNT_H: rdata = {{(8-HI_W){1'b0}}, cnt[CNT_W-1:8]};
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/tmr_tick.sv
module tmr_tick #(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] csel,
    input  logic       tick_sys4,
    input  logic       tick_hs16,
    input  logic       tick_hs64,
    input  logic       tick_sub,
    input  logic       pin_async,
    output logic       tick
);
    logic [SYNC_N:0] chain;

    genvar g;
    generate
        for (g = 0; g <= SYNC_N; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    logic pin_rise, pin_fall;
    assign pin_rise =  chain[SYNC_N-1] & ~chain[SYNC_N];
    assign pin_fall = ~chain[SYNC_N-1] &  chain[SYNC_N];

    always_comb begin
        case (csel)
            3'b000:  tick = tick_sys4;
            3'b001:  tick = 1'b1;
            3'b010:  tick = tick_hs16;
            3'b011:  tick = tick_hs64;
            3'b100,
            3'b101:  tick = tick_sub;
            3'b110:  tick = pin_rise;
            default: tick = pin_fall;
        endcase
    end

endmodule

// File: rtl/tmr_seq.sv
module tmr_seq
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       pause,
    output tmr_state_e st,
    output logic       load,
    output logic       run
);
    tmr_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_d;
    end

    always_comb begin
        st_d = st;
        unique case (st)
            ST_IDLE:  if (en) st_d = ST_LOAD;
            ST_LOAD: begin
                if (!en)        st_d = ST_IDLE;
                else if (pause) st_d = ST_PAUSE;
                else            st_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!en)        st_d = ST_IDLE;
                else if (pause) st_d = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (!en)         st_d = ST_IDLE;
                else if (!pause) st_d = ST_COUNT;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load = (st == ST_LOAD);
        run  = (st == ST_COUNT) || (st == ST_PAUSE);
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int P_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl1_t            ctl1,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [P_W-1:0]   cmp_p,
    input  logic             load,
    input  logic             run,
    input  logic             en,
    input  logic             pause,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             pin,
    output logic             irq
);
    localparam int LO_W = CNT_W - P_W;

    logic [CNT_W-1:0] p_edge, p_top, tgt, duty, nxt;
    logic             use_a, step, hit, lvl;

    assign p_edge = {cmp_p, {LO_W{1'b0}}};
    assign p_top  = p_edge - 1'b1;
    assign use_a  = (ctl1.mode == MD_PWM) ? ctl1.dpsel : ctl1.clrsel;
    assign tgt    = use_a ? cmp_a : p_top;
    assign duty   = ctl1.dpsel ? p_edge : cmp_a;
    assign step   = run & en & ~pause & tick;
    assign hit    = (cnt == cmp_a);
    assign nxt    = (cnt == tgt) ? '0 : cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= '0;
        else if (step) cnt <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= step & hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl <= 1'b0;
        end else if (load) begin
            if (ctl1.mode == MD_CMP || ctl1.mode == MD_PWM) lvl <= ctl1.init;
        end else if (step) begin
            case (ctl1.mode)
                MD_CMP: begin
                    if (hit) begin
                        case (ctl1.ofun)
                            2'b01:   lvl <= 1'b0;
                            2'b10:   lvl <= 1'b1;
                            2'b11:   lvl <= ~lvl;
                            default: ;
                        endcase
                    end
                end
                MD_PWM:  lvl <= ctl1.ofun[1] ? (nxt < duty) : ctl1.ofun[0];
                default: ;
            endcase
        end
    end

    assign pin = lvl ^ ctl1.pol;

endmodule

// File: rtl/ctr_out_timer.sv
module ctr_out_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int P_W    = 3,
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tick_sys4_i,
    input  logic       tick_hs16_i,
    input  logic       tick_hs64_i,
    input  logic       tick_sub_i,
    input  logic       ext_clk_i,
    output logic       tmr_pin_o,
    output logic       tmr_irq_o
);
    ctl0_t            ctl0_w;
    ctl1_t            ctl1_w;
    logic [CNT_W-1:0] cmp_a_w, cnt_w;
    logic [P_W-1:0]   cmp_p_w;
    logic             tick_w, load_w, run_w;
    tmr_state_e       st_w;

    tmr_regs #(.CNT_W(CNT_W), .P_W(P_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .cnt(cnt_w), .rdata(reg_rdata),
        .ctl0(ctl0_w), .ctl1(ctl1_w), .cmp_a(cmp_a_w), .cmp_p(cmp_p_w)
    );

    tmr_tick #(.SYNC_N(SYNC_N)) u_tick (
        .clk(clk), .rst_n(rst_n), .csel(ctl0_w.csel),
        .tick_sys4(tick_sys4_i), .tick_hs16(tick_hs16_i),
        .tick_hs64(tick_hs64_i), .tick_sub(tick_sub_i),
        .pin_async(ext_clk_i), .tick(tick_w)
    );

    tmr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .en(ctl0_w.en), .pause(ctl0_w.pause),
        .st(st_w), .load(load_w), .run(run_w)
    );

    tmr_core #(.CNT_W(CNT_W), .P_W(P_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctl1(ctl1_w), .cmp_a(cmp_a_w),
        .cmp_p(cmp_p_w), .load(load_w), .run(run_w), .en(ctl0_w.en),
        .pause(ctl0_w.pause), .tick(tick_w), .cnt(cnt_w),
        .pin(tmr_pin_o), .irq(tmr_irq_o)
    );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input tmr_state_e       st,
    input logic             en,
    input logic             pause,
    input tmr_mode_e        mode,
    input logic             init,
    input logic             pol,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_a,
    input logic [2:0]       reg_addr,
    input logic [7:0]       reg_rdata,
    input logic             pin,
    input logic             irq
);
    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (pin == 1'b0 && irq == 1'b0 && cnt == '0); // R1
        end
    end

    AST_CTL0_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_CTL0) |-> (reg_rdata[2:0] == 3'b000)); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_COUNT || st == ST_PAUSE) && en && !pause && tick)
        |=> (cnt == $past(cnt) + 1'b1 || cnt == '0)); // R3

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && st != ST_LOAD) |=> $stable(cnt)); // R3

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && st != ST_LOAD) |=> $stable(cnt)); // R5

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && st != ST_LOAD) |=> $stable(cnt)); // R6

    AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |=> (cnt == '0)); // R6

    AST_IRQ_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cnt == cmp_a)); // R8

    AST_INIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD && (mode == MD_CMP || mode == MD_PWM))
        |=> ((pin ^ pol) == $past(init))); // R10
endmodule

bind ctr_out_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st_w), .en(ctl0_w.en),
    .pause(ctl0_w.pause), .mode(ctl1_w.mode), .init(ctl1_w.init),
    .pol(ctl1_w.pol), .tick(tick_w), .cnt(cnt_w), .cmp_a(cmp_a_w),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .pin(tmr_pin_o),
    .irq(tmr_irq_o)
);

// File: tb/sim_ctr_out_timer.sv
module sim_ctr_out_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       t4 = 1'b0, t16 = 1'b0, t64 = 1'b0, tsub = 1'b0, ext = 1'b0;
    logic       pin, irq;

    int n_chk = 0;
    int n_fail = 0;

    int m_cnt, m_lvl, m_irq, m_a, m_p;
    logic [7:0] m_c1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_out_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick_sys4_i(t4), .tick_hs16_i(t16), .tick_hs64_i(t64),
        .tick_sub_i(tsub), .ext_clk_i(ext), .tmr_pin_o(pin), .tmr_irq_o(irq)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic get_cnt(output int v);
        int lo, hi;
        rd(3'd5, lo);
        rd(3'd6, hi);
        v = lo + hi * 256;
    endtask

    function automatic int tgt_of(input logic [7:0] c1, input int a, input int p);
        logic use_a;
        use_a = (c1[7:6] == 2'b10) ? c1[1] : c1[0];
        return use_a ? a : ((p * 128 + 1023) % 1024);
    endfunction

    function automatic int duty_of(input logic [7:0] c1, input int a, input int p);
        return c1[1] ? p * 128 : a;
    endfunction

    task automatic model_step();
        int tgt, nxt;
        bit hit;
        tgt = tgt_of(m_c1, m_a, m_p);
        hit = (m_cnt == m_a);
        nxt = (m_cnt == tgt) ? 0 : m_cnt + 1;
        m_irq = hit ? 1 : 0;
        if (m_c1[7:6] == 2'b00 && hit) begin
            case (m_c1[5:4])
                2'b01: m_lvl = 0;
                2'b10: m_lvl = 1;
                2'b11: m_lvl = 1 - m_lvl;
                default: ;
            endcase
        end else if (m_c1[7:6] == 2'b10) begin
            if (m_c1[5]) m_lvl = (nxt < duty_of(m_c1, m_a, m_p)) ? 1 : 0;
            else         m_lvl = m_c1[4] ? 1 : 0;
        end
        m_cnt = nxt;
    endtask

    // Disable, program, enable, and wait for the cleared count (R6, R10).
    task automatic start(input logic [7:0] c1, input int a, input int p, input logic [2:0] cs);
        int v;
        logic [9:0] av;
        av = a[9:0];
        wr(3'd0, 8'h00);
        wr(3'd1, c1);
        wr(3'd2, av[7:0]);
        wr(3'd3, {6'b0, av[9:8]});
        wr(3'd4, {5'b0, p[2:0]});
        wr(3'd0, {1'b0, cs, 1'b1, 3'b000});
        @(posedge clk); @(posedge clk); @(negedge clk);
        m_c1 = c1; m_a = a; m_p = p; m_cnt = 0; m_irq = 0;
        if (c1[7:6] == 2'b00 || c1[7:6] == 2'b10) m_lvl = c1[3] ? 1 : 0;
        get_cnt(v);
        chk("R6 count cleared on enable", v, 0);
        chk("R10 pin level after enable", int'(pin), m_lvl ^ int'(c1[2]));
    endtask

    task automatic run_model(input int n, input string pin_tag);
        int v;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            get_cnt(v);
            chk("R7 count value", v, m_cnt);
            chk("R8 match pulse", int'(irq), m_irq);
            chk(pin_tag, int'(pin), m_lvl ^ int'(m_c1[2]));
        end
    endtask

    task automatic ext_pattern();
        for (int k = 0; k < 3; k++) begin
            ext = 1'b1; repeat (4) @(negedge clk);
            ext = 1'b0; repeat (4) @(negedge clk);
        end
        ext = 1'b1; repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        int v, exp_t, ref_v;
        logic [7:0] c1;
        void'($urandom(32'd4057));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], v);
            chk("R1 register reset value", v, 0);
        end
        chk("R1 pin after reset", int'(pin), 0);
        chk("R1 pulse after reset", int'(irq), 0);

        // R2 register layout
        wr(3'd0, 8'h07); rd(3'd0, v); chk("R2 low bits of control 0", v, 0);
        wr(3'd1, 8'hA5); rd(3'd1, v); chk("R2 control 1 readback", v, 8'hA5);
        wr(3'd3, 8'hFF); rd(3'd3, v); chk("R2 A high bits", v, 3);
        wr(3'd4, 8'hFF); rd(3'd4, v); chk("R2 P bits", v, 7);
        wr(3'd1, 8'h00);

        // R9 compare mode: toggle, set, clear, none with inversion
        start(8'h31, 5, 0, 3'b001); run_model(20, "R9 compare toggle");
        start(8'h21, 7, 0, 3'b001); run_model(12, "R9 compare set");
        start(8'h19, 3, 0, 3'b001); run_model(10, "R9 compare clear");
        start(8'h0D, 2, 0, 3'b001); run_model(8, "R10 inverted hold");
        // R7 period from P
        start(8'h30, 20, 1, 3'b001); run_model(260, "R7 period from P");

        // R11 PWM
        start(8'hA0, 40, 1, 3'b001); run_model(140, "R11 pwm A duty");
        start(8'hA6, 9, 0, 3'b001);  run_model(25, "R11 pwm inverted zero duty");
        start(8'hA2, 300, 1, 3'b001); run_model(320, "R11 pwm P duty");
        start(8'h90, 6, 0, 3'b001);  run_model(10, "R11 pwm forced active");

        // R12 timer mode keeps the pin
        start(8'h21, 3, 0, 3'b001); run_model(8, "R9 set before timer");
        start(8'hC1, 3, 0, 3'b001); run_model(20, "R12 timer pin holds");

        // R5 pause and resume
        start(8'h00, 0, 0, 3'b001); run_model(10, "R9 no change");
        wr(3'd0, 8'h98);
        get_cnt(ref_v);
        repeat (15) @(negedge clk);
        get_cnt(v); chk("R5 count held while paused", v, ref_v);
        wr(3'd0, 8'h18);
        get_cnt(v); chk("R5 count held at resume", v, ref_v);
        repeat (7) @(negedge clk);
        get_cnt(v); chk("R5 counting resumes", v, ref_v + 7);

        // R6 disable keeps the residual value, re-enable clears
        wr(3'd0, 8'h10);
        get_cnt(ref_v);
        repeat (10) @(negedge clk);
        get_cnt(v); chk("R6 count held while off", v, ref_v);
        chk("R6 residual nonzero", int'(ref_v != 0), 1);
        wr(3'd0, 8'h18);
        @(posedge clk); @(posedge clk); @(negedge clk);
        get_cnt(v); chk("R6 re-enable clears", v, 0);

        // R3 source selection over 20 cycles of a fixed enable pattern
        for (int s = 0; s < 6; s++) begin
            logic [2:0] cs;
            cs = (s == 0) ? 3'b000 : (s == 1) ? 3'b010 : (s == 2) ? 3'b011 :
                 (s == 3) ? 3'b100 : (s == 4) ? 3'b101 : 3'b001;
            start(8'h00, 0, 0, cs);
            for (int i = 0; i < 20; i++) begin
                t4 = (i % 2 == 0); t16 = (i % 3 == 0);
                t64 = (i % 4 == 0); tsub = (i % 5 == 0);
                @(posedge clk); @(negedge clk);
            end
            t4 = 0; t16 = 0; t64 = 0; tsub = 0;
            exp_t = (s == 0) ? 10 : (s == 1) ? 7 : (s == 2) ? 5 : (s == 5) ? 20 : 4;
            get_cnt(v); chk("R3 count of selected source", v, exp_t);
        end

        // R4 external pin edges: pattern has 4 rises and 3 falls
        start(8'h00, 0, 0, 3'b110);
        ext_pattern();
        get_cnt(v); chk("R4 rising edges counted", v, 4);
        ext = 1'b0;
        start(8'h00, 0, 0, 3'b111);
        ext_pattern();
        get_cnt(v); chk("R4 falling edges counted", v, 3);
        ext = 1'b0;

        // Random configurations in compare and PWM modes
        for (int it = 0; it < 12; it++) begin
            c1 = 8'($urandom);
            c1[7:6] = ($urandom % 2 == 0) ? 2'b00 : 2'b10;
            start(c1, int'($urandom % 48), int'($urandom % 3), 3'b001);
            run_model(70, (c1[7:6] == 2'b10) ? "R11 random pwm" : "R9 random compare");
        end

        report();
        $finish;
    end

endmodule